// File: doc/BRIEF.md
# Four-Frame Circular Sample Memory Controller

This block sits behind the decimation stage of a digitizer that never stops recording. The sample clock runs freely and has no link to any beam timing. Each incoming memory word packs the samples of two channels. The block stores these words in a single-port memory that is split into four equal frames, used as a ring. A write pointer walks the ring one frame after another. A separate read pointer follows it and drains only frames that are already complete. Memory cycles strictly alternate between a write slot and a read slot, so acquisition never has to pause for readout.

Every completed frame is read out. A trigger does not decide whether a frame is kept; it decides which of two output paths the frame's words leave on. A trigger seen while frame k is being written tags both frame k and frame k+1 for the triggered path. All other frames leave on the continuous path.

The frame length is programmable in words, up to a parameter limit. A frame-sync pulse marks each boundary crossed by the writer. If the readout is held off for so long that the writer would enter a frame that is still unread, the oldest frame is dropped and an overrun pulse is raised.

Top module: `frameRing`

## Requirements
- R1: While reset is asserted, trigValid, contValid, frameSync and overrun are 0, rdWord is 0 and wrFrame is 0. After reset, nothing is read out until the first frame is complete.
- R2: The first cycle after reset is a write slot, and write and read slots then alternate. Output words appear only after read slots, so trigValid or contValid is never high in two consecutive cycles.
- R3: The writer fills frames in the order 0, 1, 2, 3, 0 and so on. When the word that completes a frame is written, frameSync pulses for one cycle and wrFrame shows the next frame index in that same cycle.
- R4: An accepted input word is {sampleHi, sampleLo}, with sampleHi in the upper SAMPLE_W bits. It is written at the next write slot, and rdWord returns it in the same packing.
- R5: Frames are read in the order they were completed, and the words within a frame in the order they were written, each exactly once. rdFrame gives the frame index. The reader never reads the frame the writer is filling.
- R6: A trigger sampled while wrFrame = k tags frame k and frame k+1. Words of a tagged frame leave with trigValid = 1.
- R7: Words of frames that are not tagged leave with contValid = 1. No frame is skipped for lack of a trigger.
- R8: The writer may complete a frame while all three other frames are still full, whether unread or partly read. In that case overrun pulses together with frameSync, the oldest frame's remaining words are discarded, and reading resumes at the frame after it.
- R9: While rdHold = 1 no read takes place. Held words are delivered later with no loss, unless they are discarded under R8.
- R10: frameLen sets the words per frame from 1 up to FRAME_WORDS_MAX. It is held constant outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameLen | input | OFS_W+1 | Words per frame, 1..FRAME_WORDS_MAX |
| inValid | input | 1 | A packed word is presented; at most one every two cycles |
| sampleLo | input | SAMPLE_W | Even-channel sample, lower half of the word |
| sampleHi | input | SAMPLE_W | Odd-channel sample, upper half of the word |
| trigger | input | 1 | Event trigger, sampled each cycle |
| rdHold | input | 1 | Downstream busy; suppresses read slots |
| trigValid | output | 1 | rdWord belongs to a triggered frame |
| contValid | output | 1 | rdWord belongs to an untriggered frame |
| rdWord | output | 2*SAMPLE_W | Word read from memory |
| rdFrame | output | 2 | Frame index of rdWord |
| wrFrame | output | 2 | Frame the writer is filling |
| frameSync | output | 1 | One-cycle pulse on each frame boundary |
| overrun | output | 1 | One-cycle pulse when the oldest frame is dropped |

## Verification
The bench drives the block with several stimulus patterns and compares every cycle against a queue-based reference model:
- A dense, trigger-free stream at frame length 4 shows that every frame comes out on the continuous path, in order.
- Sparse random triggers show that the two-frame tag is applied, including triggers that arrive on the boundary cycle.
- A long readout hold followed by release forces repeated overruns and checks that exactly the oldest frame's words vanish.
- A partial random hold with sparse input separates stalling from losing data.
- Frame lengths of 1 and the maximum exercise the offset wrap at both ends of its range.

// File: rtl/frameRingPkg.sv
package frameRingPkg;
  localparam int FRAMES      = 4;
  localparam int FRAME_IDX_W = 2;

  // strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic                   wrEn;
    logic                   rdEn;
    logic                   rdTrig;
    logic [FRAME_IDX_W-1:0] rdFrame;
  } memStrobe_t;
endpackage

// File: rtl/frameRingCtrl.sv
module frameRingCtrl
  import frameRingPkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [OFS_W:0]         frameLen,
  input  logic                   inValid,
  input  logic                   trigger,
  input  logic                   rdHold,
  output memStrobe_t             strobe,
  output logic [OFS_W+1:0]       memAddr,
  output logic [FRAME_IDX_W-1:0] wrFrame,
  output logic                   frameSync,
  output logic                   overrun
);
  localparam logic [OFS_W-1:0] OFS_ONE = 1;
  localparam logic [OFS_W:0]   LEN_ONE = 1;

  logic                   phase;    // 0 = write slot, 1 = read slot
  logic                   pend;
  logic [FRAME_IDX_W-1:0] rdPtr;
  logic [OFS_W-1:0]       wrOfs, rdOfs;
  logic [FRAMES-1:0]      full, fullNxt, trigTag;
  logic                   carry;
  logic [OFS_W:0]         lastOfs;
  logic [FRAME_IDX_W-1:0] wrNext;
  logic                   doWrite, doRead, wrLast, rdLast, collide;

  assign lastOfs = frameLen - LEN_ONE;
  assign wrNext  = wrFrame + 2'd1;
  assign doWrite = !phase && pend;
  assign doRead  = phase && !rdHold && full[rdPtr];
  assign wrLast  = doWrite && ({1'b0, wrOfs} >= lastOfs);
  assign rdLast  = doRead && ({1'b0, rdOfs} >= lastOfs);
  assign collide = wrLast && full[wrNext];

  assign strobe.wrEn    = doWrite;
  assign strobe.rdEn    = doRead;
  assign strobe.rdTrig  = trigTag[rdPtr];
  assign strobe.rdFrame = rdPtr;
  assign memAddr = phase ? {rdPtr, rdOfs} : {wrFrame, wrOfs};

  always_comb begin
    fullNxt = full;
    if (rdLast) fullNxt[rdPtr] = 1'b0;
    if (wrLast) begin
      fullNxt[wrFrame] = 1'b1;
      if (full[wrNext]) fullNxt[wrNext] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= 1'b0;
      pend      <= 1'b0;
      wrFrame   <= '0;
      rdPtr     <= '0;
      wrOfs     <= '0;
      rdOfs     <= '0;
      full      <= '0;
      trigTag   <= '0;
      carry     <= 1'b0;
      frameSync <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      phase     <= !phase;
      pend      <= inValid || (pend && !doWrite);
      full      <= fullNxt;
      frameSync <= wrLast;
      overrun   <= collide;
      if (doWrite) begin
        wrOfs <= wrLast ? '0 : wrOfs + OFS_ONE;
        if (wrLast) wrFrame <= wrNext;
      end
      if (doRead) begin
        rdOfs <= rdLast ? '0 : rdOfs + OFS_ONE;
        if (rdLast) rdPtr <= rdPtr + 2'd1;
      end else if (collide) begin
        rdOfs <= '0;
        rdPtr <= rdPtr + 2'd1;
      end
      if (trigger) trigTag[wrFrame] <= 1'b1;
      if (wrLast) begin
        trigTag[wrNext] <= carry || trigger;
        carry           <= 1'b0;
      end else if (trigger) begin
        carry <= 1'b1;
      end
    end
  end

  AST_RD_NOT_WR_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |-> (rdPtr != wrFrame)); // R5
  AST_OFS_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    ({1'b0, wrOfs} < frameLen) && ({1'b0, rdOfs} < frameLen)); // R10
endmodule

// File: rtl/frameRingData.sv
module frameRingData
  import frameRingPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int ADDR_W   = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic [SAMPLE_W-1:0]    sampleLo,
  input  logic [SAMPLE_W-1:0]    sampleHi,
  input  memStrobe_t             strobe,
  input  logic [ADDR_W-1:0]      memAddr,
  output logic                   trigValid,
  output logic                   contValid,
  output logic [2*SAMPLE_W-1:0]  rdWord,
  output logic [FRAME_IDX_W-1:0] rdFrame
);
  localparam int WORD_W = 2 * SAMPLE_W;
  localparam int DEPTH  = 2 ** ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] pendWord;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[memAddr] <= pendWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendWord  <= '0;
      trigValid <= 1'b0;
      contValid <= 1'b0;
      rdWord    <= '0;
      rdFrame   <= '0;
    end else begin
      if (inValid) pendWord <= {sampleHi, sampleLo};
      trigValid <= strobe.rdEn && strobe.rdTrig;
      contValid <= strobe.rdEn && !strobe.rdTrig;
      if (strobe.rdEn) begin
        rdWord  <= mem[memAddr];
        rdFrame <= strobe.rdFrame;
      end
    end
  end

  AST_OUT_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid || contValid) |=> !(trigValid || contValid)); // R2
endmodule

// File: rtl/frameRing.sv
module frameRing
  import frameRingPkg::*;
#(
  parameter int SAMPLE_W        = 16,
  parameter int FRAME_WORDS_MAX = 16,
  localparam int OFS_W  = $clog2(FRAME_WORDS_MAX),
  localparam int ADDR_W = FRAME_IDX_W + OFS_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [OFS_W:0]         frameLen,
  input  logic                   inValid,
  input  logic [SAMPLE_W-1:0]    sampleLo,
  input  logic [SAMPLE_W-1:0]    sampleHi,
  input  logic                   trigger,
  input  logic                   rdHold,
  output logic                   trigValid,
  output logic                   contValid,
  output logic [2*SAMPLE_W-1:0]  rdWord,
  output logic [FRAME_IDX_W-1:0] rdFrame,
  output logic [FRAME_IDX_W-1:0] wrFrame,
  output logic                   frameSync,
  output logic                   overrun
);
  memStrobe_t        strobe;
  logic [ADDR_W-1:0] memAddr;

  frameRingCtrl #(.OFS_W(OFS_W)) ctrl (
    .clk(clk), .rstN(rstN), .frameLen(frameLen), .inValid(inValid),
    .trigger(trigger), .rdHold(rdHold), .strobe(strobe), .memAddr(memAddr),
    .wrFrame(wrFrame), .frameSync(frameSync), .overrun(overrun)
  );

  frameRingData #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) data (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sampleLo(sampleLo),
    .sampleHi(sampleHi), .strobe(strobe), .memAddr(memAddr),
    .trigValid(trigValid), .contValid(contValid), .rdWord(rdWord),
    .rdFrame(rdFrame)
  );

  AST_SYNC_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |-> (wrFrame == $past(wrFrame) + 2'd1)); // R3
  AST_OVERRUN_ON_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> frameSync); // R8
  AST_HOLD_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    (trigValid || contValid) |-> !$past(rdHold)); // R9
endmodule

// File: tb/frameRing_test.sv
module frameRing_test;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 16;
  localparam int MAXW = 16;
  localparam int LW = $clog2(MAXW) + 1;

  logic clk = 0, rstN = 0, inValid = 0, trigger = 0, rdHold = 0;
  logic [LW-1:0] frameLen = 4;
  logic [SW-1:0] sampleLo = 0, sampleHi = 0;
  logic trigValid, contValid, frameSync, overrun;
  logic [2*SW-1:0] rdWord;
  logic [1:0] rdFrame, wrFrame;

  int nChecks = 0, nFails = 0;
  int sawOver = 0, sawTrig = 0, sawCont = 0, sawSync = 0;
  bit running = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frameRing #(.SAMPLE_W(SW), .FRAME_WORDS_MAX(MAXW)) uut (
    .clk(clk), .rstN(rstN), .frameLen(frameLen), .inValid(inValid),
    .sampleLo(sampleLo), .sampleHi(sampleHi), .trigger(trigger), .rdHold(rdHold),
    .trigValid(trigValid), .contValid(contValid), .rdWord(rdWord), .rdFrame(rdFrame),
    .wrFrame(wrFrame), .frameSync(frameSync), .overrun(overrun)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: written words collect in a frame queue, completed
  // frames move to a readout queue of tagged records
  typedef struct packed { logic [31:0] d; logic [1:0] f; logic t; logic last; } rec_t;
  logic [31:0] wq[$];
  rec_t rq[$];
  rec_t rec;
  int nFull, mPhase, mFrame;
  bit mPend, curTag, trigSeen, tagDone, completing;
  logic [31:0] mPendWord;
  logic eTrigV, eContV, eSync, eOver;
  logic [31:0] eData;
  logic [1:0] eFrame;
  logic [1:0] dropF;

  always @(posedge clk) begin
    if (!rstN) begin
      wq.delete(); rq.delete();
      nFull = 0; mPhase = 0; mFrame = 0; mPend = 0; curTag = 0; trigSeen = 0;
      eTrigV = 0; eContV = 0; eSync = 0; eOver = 0; eData = 0; eFrame = 0;
    end else begin
      eTrigV = 0; eContV = 0; eSync = 0; eOver = 0;
      completing = (mPhase == 0) && mPend && (wq.size() + 1 == int'(frameLen));
      if (mPhase == 0 && mPend) begin
        wq.push_back(mPendWord);
        mPend = 0;
        if (completing) begin
          tagDone = curTag | trigger;
          if (nFull == 3) begin
            dropF = rq[0].f;
            while (rq.size() > 0 && rq[0].f == dropF) void'(rq.pop_front());
            eOver = 1;
          end else nFull++;
          for (int i = 0; i < wq.size(); i++) begin
            rec.d = wq[i]; rec.f = 2'(mFrame); rec.t = tagDone;
            rec.last = (i == wq.size() - 1);
            rq.push_back(rec);
          end
          wq.delete();
          mFrame = (mFrame + 1) % 4;
          eSync = 1;
          curTag = trigSeen | trigger;
          trigSeen = 0;
        end
      end
      if (trigger && !completing) begin curTag = 1; trigSeen = 1; end
      if (inValid) begin mPend = 1; mPendWord = {sampleHi, sampleLo}; end
      if (mPhase == 1 && !rdHold && nFull > 0) begin
        rec = rq.pop_front();
        eTrigV = rec.t; eContV = !rec.t; eData = rec.d; eFrame = rec.f;
        if (rec.last) nFull--;
      end
      mPhase = 1 - mPhase;
    end
  end

  always @(negedge clk) begin
    if (rstN && running) begin
      check("R6 triggered path valid", 32'(trigValid), 32'(eTrigV));
      check("R7 continuous path valid", 32'(contValid), 32'(eContV));
      if (eTrigV || eContV) begin
        check("R4 word packing and data", rdWord, eData);
        check("R5 readout frame order", 32'(rdFrame), 32'(eFrame));
      end
      check("R3 write frame index", 32'(wrFrame), 32'(mFrame));
      check("R3 frame sync pulse", 32'(frameSync), 32'(eSync));
      check("R8 overrun pulse", 32'(overrun), 32'(eOver));
      if (overrun) sawOver++;
      if (trigValid) sawTrig++;
      if (contValid) sawCont++;
      if (frameSync) sawSync++;
    end
  end

  task automatic doReset(int len);
    @(negedge clk);
    rstN = 0; inValid = 0; trigger = 0; rdHold = 0; frameLen = LW'(len);
    repeat (2) @(negedge clk);
    // R1: quiet outputs while reset is held
    check("R1 reset trigValid", 32'(trigValid), 0);
    check("R1 reset contValid", 32'(contValid), 0);
    check("R1 reset rdWord", rdWord, 0);
    check("R1 reset wrFrame", 32'(wrFrame), 0);
    check("R1 reset frameSync/overrun", 32'({frameSync, overrun}), 0);
    rstN = 1;
  endtask

  task automatic runSeg(int cycles, int gap, int trigPct, int holdPct);
    int cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      inValid = (cnt == 0);
      sampleLo = SW'($urandom);
      sampleHi = SW'($urandom);
      trigger = ($urandom_range(99) < trigPct);
      rdHold = ($urandom_range(99) < holdPct);
      cnt = (cnt + 1) % gap;
    end
    @(negedge clk);
    inValid = 0; trigger = 0; rdHold = 0;
  endtask

  initial begin
    running = 1;
    doReset(4);
    runSeg(200, 2, 0, 0);     // R7: no triggers, all continuous
    runSeg(300, 2, 3, 0);     // R6: sparse triggers
    runSeg(120, 2, 2, 100);   // R8: readout held, writer laps the reader
    runSeg(150, 2, 0, 0);
    runSeg(400, 5, 2, 50);    // R9: partial hold, sparse input
    doReset(1);
    runSeg(200, 2, 5, 0);     // R10: one word per frame
    doReset(16);
    runSeg(600, 3, 2, 20);    // R10: maximum frame length
    runSeg(200, 2, 0, 0);
    check("R8 overrun observed", 32'(sawOver > 0), 1);
    check("R6 triggered words observed", 32'(sawTrig > 0), 1);
    check("R7 continuous words observed", 32'(sawCont > 0), 1);
    check("R3 frame boundaries observed", 32'(sawSync > 0), 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule